// File: doc/BRIEF.md
# Nibble ADPCM Block Decoder

This block sits between a byte-wide sample FIFO and an audio sample consumer. Each time the consumer asks for a sample, the block either hands over the next FIFO byte unchanged (pass-through mode) or runs one step of a 4-bit adaptive differential decoder. In decode mode the byte stream is cut into packets. Each packet is one header byte followed by fourteen data bytes, which yield twenty-eight samples. The header chooses a right shift for the nibble and one of sixteen prediction filters. Each filter is a pair of programmable signed 8-bit coefficients held in a small bank.

Each decoded sample is a saturated signed 16-bit value built from the shifted nibble plus a second-order prediction over the two previous results. The sample leaves the block as an unsigned byte. When the FIFO has no byte at the moment one is needed, the block returns the mid-scale filler code and leaves its decoder state as it was. A flush input puts the decoder back into the state where it waits for a header. This is meant to go together with a reset of the FIFO.

Top module: `adpcm_nibble_decoder`

## Requirements
- R1: When `(ctrl & 0x83) == 0x82` the block decodes. Any other `ctrl` value (for example 0x80, 0x00, 0x81, 0x83, 0x02) selects pass-through. In pass-through, a request with a non-empty FIFO pops one byte and returns it with `smp_fresh`=1, one cycle after the request edge. The decoder's packet position, header and history are kept unchanged while pass-through is selected.
- R2: In pass-through, a request made while the FIFO is empty returns 0x80 with `smp_fresh`=0 and pops nothing.
- R3: In decode mode, the first byte of a packet is a header. Bits 3:0 give the shift and bits 7:4 give the filter index. Popping a header gives no sample of its own. The same request then continues for one more cycle, so its sample appears two cycles after the request edge instead of one.
- R4: A packet delivers exactly 28 decoded samples from 14 data bytes. The byte after the last data byte is taken as a new header.
- R5: Each data byte is popped only for an even-numbered sample of the packet. Its low nibble is used first and its high nibble second. The odd sample uses the byte already held and needs no FIFO data.
- R6: The nibble is placed in bits 15:12 of a signed 16-bit value d. The sample is t = (d >>> shift) + ((h0*f0 + h1*f1 + 32) >>> 6), using arithmetic shifts. Here h0 is the latest decoded sample and h1 the one before it. After each sample, h1 takes h0 and h0 takes t.
- R7: The coefficient bank holds signed bytes written through `coef_we`/`coef_addr`/`coef_wdata`. For filter n, f1 is at address 2n and f0 at address 2n+1.
- R8: t saturates to the range -32768 to 32767 before it is output and before it enters the history.
- R9: The output byte is (t / 256, truncated toward zero) XOR 0x80.
- R10: In decode mode, if a byte is needed and the FIFO is empty, the block outputs 0x80 with `smp_fresh`=0. The packet position and the history do not change. This includes the case where a header was just consumed.
- R11: A `flush` cycle produces no sample and pops nothing. It returns the decoder to waiting for a header and keeps the history.
- R12: After reset: `smp_valid`=0, `smp_byte`=0x80, history zero, all coefficients zero, and the decoder waits for a header.
- R13: `fifo_pop` is never asserted while `fifo_empty` is high. With no request pending it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl | input | 8 | Mode control byte for this FIFO |
| flush | input | 1 | Return decoder to waiting for a header |
| coef_we | input | 1 | Coefficient bank write enable |
| coef_addr | input | 5 | Coefficient bank address |
| coef_wdata | input | 8 | Coefficient value (signed) |
| fifo_empty | input | 1 | Sample FIFO has no byte |
| fifo_rdata | input | 8 | Byte at the FIFO head |
| fifo_pop | output | 1 | Consume the FIFO head byte this cycle |
| smp_req | input | 1 | Consumer asks for one sample |
| smp_valid | output | 1 | One-cycle strobe: `smp_byte` holds a new result |
| smp_byte | output | 8 | Unsigned 8-bit output sample |
| smp_fresh | output | 1 | Result came from FIFO data (0 for filler) |

## Verification
The assertions assume two things about the inputs. First, `fifo_rdata` is the head byte whenever `fifo_empty` is low. Second, requests, flushes and mode changes are only driven while reset is released. The stimulus drives every input on the falling edge from a modelled FIFO whose head always matches its count. It waits for each sample strobe before issuing the next request and changes `ctrl` only between requests. It sweeps every shift against every filter, pushes each packet only after the previous one has drained, and removes bytes at chosen points to exercise the starvation paths.

// File: rtl/adpcm_pkg.sv
// Shared constants and types for the nibble ADPCM decoder.
// Assumes an 8-bit sample FIFO and a 16-bit internal sample width.
package adpcm_pkg;

    localparam int BYTE_W  = 8;
    localparam int NIB_W   = 4;
    localparam int SHIFT_W = 4;
    localparam int FILT_W  = 4;
    localparam int SMP_W   = 16;

    localparam logic [BYTE_W-1:0] CTRL_MASK   = 8'h83;
    localparam logic [BYTE_W-1:0] CTRL_DECODE = 8'h82;
    localparam logic [BYTE_W-1:0] FILLER      = 8'h80;

    // Decoder sequencing phase: idle, or finishing a request after a header pop
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    // Packet header layout: filter index in the upper nibble, shift in the lower
    typedef struct packed {
        logic [FILT_W-1:0]  filt;
        logic [SHIFT_W-1:0] shift;
    } hdr_t;

    // True when the control byte selects decoding rather than pass-through
    function automatic logic is_decode(input logic [BYTE_W-1:0] c);
        return (c & CTRL_MASK) == CTRL_DECODE;
    endfunction

endpackage

// File: rtl/adpcm_coef_bank.sv
// Programmable bank of signed 8-bit prediction coefficients.
// Holds two bytes per filter: even address = f1 (older sample weight),
// odd address = f0 (newer sample weight). Reads are combinational.
// Assumes one write port and a filter select that is always in range.
module adpcm_coef_bank #(
    parameter  int FW = 4,
    localparam int NUM_FILT = 1 << FW,
    localparam int DEPTH = 2 * NUM_FILT,
    localparam int AW = FW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [7:0]        wdata,
    input  logic [FW-1:0]     sel,
    output logic signed [7:0] f0,
    output logic signed [7:0] f1
);

    logic [7:0] mem [DEPTH];

    // Storage: clear on reset, single-byte writes afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Coefficient pair lookup for the selected filter
    always_comb begin
        f1 = $signed(mem[{sel, 1'b0}]);
        f0 = $signed(mem[{sel, 1'b1}]);
    end

endmodule

// File: rtl/adpcm_predict.sv
// Combinational second-order predictor with saturation.
// Places the nibble in the top bits of a 16-bit value, shifts it right
// arithmetically, adds the rounded coefficient-weighted history and
// clamps the sum to the signed 16-bit range.
// Assumes history and coefficients are two's complement.
module adpcm_predict #(
    parameter  int NW = 4,
    parameter  int SW = 4,
    parameter  int DW = 16,
    parameter  int CW = 8,
    localparam int PW = DW + CW,
    localparam int AW = PW + 2,
    localparam int RW = AW + 1
) (
    input  logic [NW-1:0]        nib,
    input  logic [SW-1:0]        shift,
    input  logic signed [CW-1:0] f0,
    input  logic signed [CW-1:0] f1,
    input  logic signed [DW-1:0] h0,
    input  logic signed [DW-1:0] h1,
    output logic signed [DW-1:0] t
);

    localparam logic signed [DW-1:0] SAT_HI = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] SAT_LO = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW-1:0] d, d_sh;
    logic signed [PW-1:0] p0, p1;
    logic signed [AW-1:0] acc, acc_sh;
    logic signed [RW-1:0] sum;

    // Step value: nibble at the top, scaled down by the header shift
    always_comb begin
        d    = {nib, {(DW-NW){1'b0}}};
        d_sh = d >>> shift;
    end

    // Weighted history with rounding before the divide by 64
    always_comb begin
        p0     = h0 * f0;
        p1     = h1 * f1;
        acc    = AW'(p0) + AW'(p1) + AW'(32);
        acc_sh = acc >>> 6;
    end

    // Sum and clamp to the sample range
    always_comb begin
        sum = RW'(d_sh) + RW'(acc_sh);
        if (sum > RW'(SAT_HI)) begin
            t = SAT_HI;
        end else if (sum < RW'(SAT_LO)) begin
            t = SAT_LO;
        end else begin
            t = sum[DW-1:0];
        end
    end

endmodule

// File: rtl/adpcm_to_u8.sv
// Converts a signed 16-bit sample to an unsigned 8-bit code.
// Divides by 256 rounding toward zero, then flips the sign bit so that
// zero maps to mid-scale. Assumes a full-range signed input.
module adpcm_to_u8 #(
    parameter  int DW = 16,
    localparam int OW = 8
) (
    input  logic signed [DW-1:0] t,
    output logic [OW-1:0]        b
);

    logic          bump;
    logic [OW-1:0] q;

    // Floor division plus one for negative values with a non-zero remainder
    always_comb begin
        bump = t[DW-1] && (t[DW-OW-1:0] != '0);
        q    = t[DW-1 -: OW] + OW'(bump);
        b    = q ^ {1'b1, {(OW-1){1'b0}}};
    end

endmodule

// File: rtl/adpcm_nibble_decoder.sv
// Streaming nibble ADPCM decoder in front of a byte FIFO.
// One request gives one output byte: a pass-through byte, a decoded
// sample, or the filler code when the FIFO is starved. In decode mode a
// header pop takes one extra cycle before the sample is produced.
// Assumes the consumer waits for smp_valid before the next request and
// that fifo_rdata shows the head byte whenever fifo_empty is low.
module adpcm_nibble_decoder
    import adpcm_pkg::*;
#(
    parameter  int SAMPLES_PER_PKT = 28,
    localparam int COEF_AW = FILT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BYTE_W-1:0]  ctrl,
    input  logic               flush,
    input  logic               coef_we,
    input  logic [COEF_AW-1:0] coef_addr,
    input  logic [BYTE_W-1:0]  coef_wdata,
    input  logic               fifo_empty,
    input  logic [BYTE_W-1:0]  fifo_rdata,
    output logic               fifo_pop,
    input  logic               smp_req,
    output logic               smp_valid,
    output logic [BYTE_W-1:0]  smp_byte,
    output logic               smp_fresh
);

    localparam int IDX_W = $clog2(SAMPLES_PER_PKT);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SAMPLES_PER_PKT - 1);

    phase_e               phase_q;
    logic                 need_hdr_q;
    logic [IDX_W-1:0]     idx_q;
    hdr_t                 hdr_q;
    logic [BYTE_W-1:0]    held_q;
    logic signed [SMP_W-1:0] h0_q, h1_q;

    logic                 dec_mode, accept, raw_go, hdr_go, step_go, step_ok;
    logic                 want_byte, busy;
    logic [NIB_W-1:0]     nib;
    logic signed [7:0]    f0, f1;
    logic signed [SMP_W-1:0] t_new;
    logic [BYTE_W-1:0]    t_byte;

    // Request decoding and FIFO pop generation
    always_comb begin
        dec_mode  = is_decode(ctrl);
        busy      = (phase_q == PH_DATA);
        accept    = !busy && smp_req && !flush;
        raw_go    = accept && !dec_mode;
        hdr_go    = accept && dec_mode && need_hdr_q;
        step_go   = !flush && (busy || (accept && dec_mode && !need_hdr_q));
        want_byte = raw_go || hdr_go || (step_go && !idx_q[0]);
        fifo_pop  = want_byte && !fifo_empty;
        step_ok   = step_go && (idx_q[0] || !fifo_empty);
        nib       = idx_q[0] ? held_q[BYTE_W-1 -: NIB_W] : fifo_rdata[NIB_W-1:0];
    end

    adpcm_coef_bank #(.FW(FILT_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .addr  (coef_addr),
        .wdata (coef_wdata),
        .sel   (hdr_q.filt),
        .f0    (f0),
        .f1    (f1)
    );

    adpcm_predict #(.NW(NIB_W), .SW(SHIFT_W), .DW(SMP_W), .CW(8)) u_pred (
        .nib   (nib),
        .shift (hdr_q.shift),
        .f0    (f0),
        .f1    (f1),
        .h0    (h0_q),
        .h1    (h1_q),
        .t     (t_new)
    );

    adpcm_to_u8 #(.DW(SMP_W)) u_conv (
        .t (t_new),
        .b (t_byte)
    );

    // Packet sequencing: phase, header wait, sample index and header fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            need_hdr_q <= 1'b1;
            idx_q      <= '0;
            hdr_q      <= '0;
        end else if (flush) begin
            phase_q    <= PH_IDLE;
            need_hdr_q <= 1'b1;
            idx_q      <= '0;
        end else if (hdr_go) begin
            if (!fifo_empty) begin
                hdr_q      <= hdr_t'(fifo_rdata);
                need_hdr_q <= 1'b0;
                phase_q    <= PH_DATA;
            end
        end else if (step_go) begin
            phase_q <= PH_IDLE;
            if (step_ok) begin
                if (idx_q == IDX_LAST) begin
                    idx_q      <= '0;
                    need_hdr_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Decoder history and held data byte, updated only by real samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h0_q   <= '0;
            h1_q   <= '0;
            held_q <= '0;
        end else if (step_ok) begin
            h1_q <= h0_q;
            h0_q <= t_new;
            if (!idx_q[0]) begin
                held_q <= fifo_rdata;
            end
        end
    end

    // Output register: one strobe per completed request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_byte  <= FILLER;
            smp_fresh <= 1'b0;
        end else begin
            smp_valid <= 1'b0;
            if (raw_go) begin
                smp_valid <= 1'b1;
                smp_byte  <= fifo_empty ? FILLER : fifo_rdata;
                smp_fresh <= !fifo_empty;
            end else if (hdr_go && fifo_empty) begin
                smp_valid <= 1'b1;
                smp_byte  <= FILLER;
                smp_fresh <= 1'b0;
            end else if (step_go) begin
                smp_valid <= 1'b1;
                smp_byte  <= step_ok ? t_byte : FILLER;
                smp_fresh <= step_ok;
            end
        end
    end

endmodule

// File: rtl/adpcm_dec_checker.sv
// Protocol and behaviour checks for the nibble ADPCM decoder, bound to
// the top module. Assumes requests only while reset is released.
module adpcm_dec_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctrl,
    input logic       flush,
    input logic       fifo_empty,
    input logic [7:0] fifo_rdata,
    input logic       fifo_pop,
    input logic       smp_req,
    input logic       smp_valid,
    input logic [7:0] smp_byte,
    input logic       smp_fresh,
    input logic       busy,
    input logic       need_hdr
);

    logic pass_mode;
    assign pass_mode = (ctrl & 8'h83) != 8'h82;

    // R13: never consume from an empty FIFO
    assert_no_pop_empty_R13: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R13: without a request or an open request, nothing is consumed
    assert_idle_no_pop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_req && !busy) |-> !fifo_pop);

    // R10: a result not taken from data is always the filler code
    assert_filler_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_fresh) |-> (smp_byte == 8'h80));

    // R11: a flush cycle yields no sample and consumes nothing
    assert_flush_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!fifo_pop ##1 !smp_valid));

    // R1: pass-through pop returns that very byte on the next cycle
    assert_raw_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && smp_req && !busy && !flush && pass_mode)
        |=> (smp_valid && smp_fresh && smp_byte == $past(fifo_rdata)));

    // R3: a header pop gives no sample yet and opens the second phase
    assert_hdr_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && smp_req && !busy && !flush && !pass_mode && need_hdr)
        |=> (!smp_valid && busy));

    // R3: the second phase lasts exactly one cycle and always answers
    assert_phase_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !flush) |=> (!busy && smp_valid));

endmodule

bind adpcm_nibble_decoder adpcm_dec_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .flush      (flush),
    .fifo_empty (fifo_empty),
    .fifo_rdata (fifo_rdata),
    .fifo_pop   (fifo_pop),
    .smp_req    (smp_req),
    .smp_valid  (smp_valid),
    .smp_byte   (smp_byte),
    .smp_fresh  (smp_fresh),
    .busy       (busy),
    .need_hdr   (need_hdr_q)
);

// File: tb/sim_adpcm_nibble_decoder.sv
module sim_adpcm_nibble_decoder;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] ctrl;
    logic       flush;
    logic       coef_we;
    logic [4:0] coef_addr;
    logic [7:0] coef_wdata;
    logic       fifo_empty;
    logic [7:0] fifo_rdata;
    logic       fifo_pop;
    logic       smp_req;
    logic       smp_valid;
    logic [7:0] smp_byte;
    logic       smp_fresh;

    always #5 clk = ~clk;

    adpcm_nibble_decoder u0 (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .flush(flush),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
        .smp_req(smp_req), .smp_valid(smp_valid), .smp_byte(smp_byte),
        .smp_fresh(smp_fresh)
    );

    // Modelled FIFO (ring of 1024 bytes)
    logic [7:0] fq [1024];
    int wr;
    int rd;
    assign fifo_empty = (rd == wr);
    assign fifo_rdata = fq[rd % 1024];

    always @(posedge clk) begin
        if (!rst_n) rd <= 0;
        else if (fifo_pop) rd <= rd + 1;
    end

    // Reference decoder state
    int  mh0, mh1, midx, mshift, mfilt, mheld;
    bit  mneed;
    int  mcoef [32];
    int  sat_pos, sat_neg;
    int  n_chk, n_fail;
    bit  done;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic push(input int b);
        fq[wr % 1024] = b[7:0];
        wr++;
    endtask

    task automatic drop_all();
        @(negedge clk);
        wr = rd;
    endtask

    task automatic wcoef(input int a, input int v);
        @(negedge clk);
        coef_we = 1'b1; coef_addr = a[4:0]; coef_wdata = v[7:0];
        @(negedge clk);
        coef_we = 1'b0;
        mcoef[a] = v;
    endtask

    task automatic request(input string rq);
        int avail, pos, lat, pops, eb, alat, rd0, nib, d, u, t, f0, f1;
        bit ef, dec, go, ok2;
        avail = wr - rd; pos = rd; rd0 = rd;
        lat = 1; pops = 0; eb = 128; ef = 0;
        dec = ((ctrl & 8'h83) == 8'h82);
        if (!dec) begin
            if (avail > 0) begin eb = fq[pos % 1024]; ef = 1; pops = 1; end
        end else begin
            go = 1;
            if (mneed) begin
                if (avail == 0) go = 0;
                else begin
                    mshift = fq[pos % 1024] & 15;
                    mfilt  = (fq[pos % 1024] >> 4) & 15;
                    mneed = 0; pops = 1; lat = 2;
                end
            end
            if (go) begin
                ok2 = 1;
                nib = 0;
                if (midx % 2 == 0) begin
                    if (avail - pops == 0) ok2 = 0;
                    else begin
                        mheld = fq[(pos + pops) % 1024];
                        pops++;
                        nib = mheld & 15;
                    end
                end else begin
                    nib = (mheld >> 4) & 15;
                end
                if (ok2) begin
                    f1 = mcoef[2 * mfilt];
                    f0 = mcoef[2 * mfilt + 1];
                    d  = (nib >= 8 ? nib - 16 : nib) * 4096;
                    u  = (d >>> mshift) + ((mh0 * f0 + mh1 * f1 + 32) >>> 6);
                    t  = u;
                    if (u > 32767) begin t = 32767; sat_pos++; end
                    if (u < -32768) begin t = -32768; sat_neg++; end
                    eb = ((t / 256) ^ 128) & 255;
                    ef = 1;
                    mh1 = mh0; mh0 = t;
                    if (midx == 27) begin midx = 0; mneed = 1; end
                    else midx++;
                end
            end
        end
        @(negedge clk);
        smp_req = 1'b1;
        @(negedge clk);
        smp_req = 1'b0;
        alat = 1;
        if (!smp_valid) begin
            @(negedge clk);
            alat = 2;
        end
        chk(smp_valid == 1'b1, {rq, " valid"}, smp_valid, 1);
        chk(alat == lat, {rq, " latency R3"}, alat, lat);
        chk(smp_byte == eb[7:0], {rq, " byte"}, smp_byte, eb);
        chk(smp_fresh == ef, {rq, " fresh"}, smp_fresh, ef);
        chk(rd - rd0 == pops, {rq, " pops"}, rd - rd0, pops);
        chk(rd <= wr, "R13 no pop past empty", rd, wr);
    endtask

    task automatic do_flush(input bit with_req);
        int rd0;
        rd0 = rd;
        @(negedge clk);
        flush = 1'b1; smp_req = with_req;
        @(negedge clk);
        flush = 1'b0; smp_req = 1'b0;
        chk(smp_valid == 1'b0, "R11 flush gives no sample", smp_valid, 0);
        chk(rd == rd0, "R11 flush pops nothing", rd - rd0, 0);
        mneed = 1; midx = 0;
    endtask

    initial begin
        wr = 0; done = 0;
        n_chk = 0; n_fail = 0; sat_pos = 0; sat_neg = 0;
        mh0 = 0; mh1 = 0; midx = 0; mshift = 0; mfilt = 0; mheld = 0; mneed = 1;
        for (int i = 0; i < 32; i++) mcoef[i] = 0;
        rst_n = 1'b0; ctrl = 8'h80; flush = 1'b0; coef_we = 1'b0;
        coef_addr = '0; coef_wdata = '0; smp_req = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk(smp_valid == 1'b0, "R12 valid after reset", smp_valid, 0);
        chk(smp_byte == 8'h80, "R12 byte after reset", smp_byte, 128);
        chk(fifo_pop == 1'b0, "R12 no pop after reset", fifo_pop, 0);

        // R1/R2: pass-through under several control values
        ctrl = 8'h80; request("R2 raw empty");
        push(8'h3C); push(8'hA5); push(8'h00); push(8'hFF); push(8'h81);
        ctrl = 8'h80; request("R1 raw 0x80");
        ctrl = 8'h00; request("R1 raw 0x00");
        ctrl = 8'h83; request("R1 raw 0x83");
        ctrl = 8'h81; request("R1 raw 0x81");
        ctrl = 8'h02; request("R1 raw 0x02");
        request("R2 raw empty again");

        // R10/R12: decode with header starvation, history from reset (zero)
        for (int n = 1; n < 14; n++) begin
            wcoef(2 * n, ((n * 53 + 7) % 256) - 128);
            wcoef(2 * n + 1, ((n * 91 + 200) % 256) - 128);
        end
        wcoef(28, -128); wcoef(29, -128);
        wcoef(30, 127);  wcoef(31, 127);
        ctrl = 8'h82;
        request("R10 header needed, empty");
        push(8'h33);
        request("R10 header taken, data empty");
        push(8'h21);
        request("R12 first sample, zero history");
        request("R5 high nibble without FIFO data");
        request("R10 even sample starved");
        push(8'h9E);
        request("R5 low nibble");
        ctrl = 8'h80; push(8'h55);
        request("R1 raw between decodes");
        ctrl = 8'hC2;
        request("R1 decode with 0xC2, state kept");

        // R11: flush mid-packet, next byte is a header
        push(8'h4B); push(8'h10);
        do_flush(1'b1);
        request("R11 after flush, header path");
        request("R11 odd sample after flush");
        do_flush(1'b0);
        drop_all();

        // R8/R9: directed saturation both ways
        ctrl = 8'h82;
        push(8'hF0); for (int k = 0; k < 14; k++) push(8'h77);
        for (int s = 0; s < 28; s++) request("R8 positive saturation");
        push(8'h00); for (int k = 0; k < 14; k++) push(8'h88);
        for (int s = 0; s < 28; s++) request("R9 full negative");
        push(8'hF0); for (int k = 0; k < 14; k++) push(8'h88);
        for (int s = 0; s < 28; s++) request("R8 negative saturation");
        chk(sat_pos > 0, "R8 positive clamp reached", sat_pos, 1);
        chk(sat_neg > 0, "R8 negative clamp reached", sat_neg, 1);

        // R4/R6/R7: sweep every shift against every filter
        for (int sh = 0; sh < 16; sh++) begin
            for (int f = 0; f < 16; f++) begin
                push(f * 16 + sh);
                for (int k = 0; k < 14; k++) push((sh * 37 + f * 11 + k * 29 + 5) % 256);
                for (int s = 0; s < 28; s++) request("R6 sweep sample");
                chk(rd == wr, "R4 packet fully consumed", wr - rd, 0);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule